// File: doc/BRIEF.md
# Software Write-Lock Command Detector

This block sits beside the page-write controller of a byte-wide nonvolatile memory. It watches each accepted bus write, which carries a 15-bit address and a data byte. It looks for fixed address/data key sequences that lock the array against stray writes, unlock it, or let a single write burst through while the lock is on. For every write it answers in the same cycle with two signals. One says whether the byte may be committed to the array. The other says whether the byte is a command byte that must be dropped.

Writes arrive in a load window. Each accepted write restarts an idle timer. When the timer runs out, the window closes and a write period (busy) of fixed length begins. This happens even when nothing will be committed. A key sequence must fit inside one load window. The lock flag changes only when the write period that follows the sequence ends. Once set, it stays set until the release sequence is issued.

Top module: `wp_cmd_detect`

## Requirements
- R1: After reset, protectOn, busy, commitOk and swallow are all 0.
- R2: While unprotected, an accepted write that is not a key byte gives commitOk=1 and swallow=0 in the same cycle.
- R3: Key bytes give swallow=1 and commitOk=0. Only the expected next step counts as a key byte: AA at 5555h, then 55 at 2AAAh, then A0 or 80 at 5555h; after 80 comes AA at 5555h, 55 at 2AAAh, then 20 at 5555h.
- R4: The unlock triple AA@5555h, 55@2AAAh, A0@5555h sets protectOn at the end of the write period that follows the window. Later writes in the same window commit.
- R5: While protected, a window with no key sequence commits nothing and swallows nothing. It still runs a full write period, and protectOn stays 1.
- R6: While protected, writes that follow the unlock triple in the same window give commitOk=1.
- R7: The six-byte release sequence (AA, 55, 80, AA, 55, 20 at 5555h/2AAAh/5555h/5555h/2AAAh/5555h) clears protectOn at the end of the following write period. Writes after it in the same window commit.
- R8: The load window closes LOAD_TIMEOUT cycles after the last accepted write with no further write. busy is then 1 for exactly WRITE_CYCLES cycles.
- R9: When the window closes partway through a sequence, the partial match is dropped. The next byte is judged from the first step.
- R10: A byte that does not match the expected step resets the matcher. That byte is treated as an ordinary write under the current lock state.
- R11: Writes presented while busy is 1 are ignored: commitOk=0, swallow=0, and the matcher and the lock flag are not affected.
- R12: protectOn changes only in the cycle where a write period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A bus write is presented this cycle |
| wrAddr | input | 15 | Write address |
| wrData | input | 8 | Write data byte |
| commitOk | output | 1 | The presented byte may be stored |
| swallow | output | 1 | The presented byte is a key byte and must be dropped |
| protectOn | output | 1 | Write lock is active |
| busy | output | 1 | Write period in progress |

## Verification
The bench applies several kinds of window. A plain data write shows the unprotected path. A key byte followed by a wrong byte separates matcher reset from swallowing. The unlock triple with trailing data shows that locking is deferred and that the following write goes through. A bare write while locked shows that a rejected window still burns a write period. A triple broken by a timeout, with one more write landing during busy, shows that partial matches are abandoned and that writes in busy are ignored. Last comes the six-byte release, where the lock holds until the write period ends. A behavioural model is compared with all four outputs on every cycle.

// File: rtl/wp_cmd_pkg.sv
package wp_cmd_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] KEY_ADDR_HI = 15'h5555;
  localparam logic [ADDR_W-1:0] KEY_ADDR_LO = 15'h2AAA;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
  localparam logic [DATA_W-1:0] KEY_UNLOCK = 8'hA0;
  localparam logic [DATA_W-1:0] KEY_EXTEND = 8'h80;
  localparam logic [DATA_W-1:0] KEY_FREE   = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4, ST_K5, ST_AUTH
  } step_e;

  // control -> datapath
  typedef struct packed {
    logic idleRestart;
    logic idleRun;
    logic busyStart;
    logic busyRun;
  } strobe_t;

  // datapath -> control: pattern hits on the current bus byte
  typedef struct packed {
    logic first;
    logic second;
    logic unlock;
    logic extend;
    logic free;
  } hit_t;
endpackage

// File: rtl/wp_cmd_dpath.sv
module wp_cmd_dpath
  import wp_cmd_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 16,
  parameter int WRITE_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strobes,
  output hit_t              hits,
  output logic              idleExpired,
  output logic              busyDone
);
  localparam int IDLE_W = (LOAD_TIMEOUT > 1) ? $clog2(LOAD_TIMEOUT) : 1;
  localparam int BUSY_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(LOAD_TIMEOUT - 1);
  localparam logic [BUSY_W-1:0] BUSY_LAST = BUSY_W'(WRITE_CYCLES - 1);

  logic [IDLE_W-1:0] idleCnt;
  logic [BUSY_W-1:0] busyCnt;

  logic atHi, atLo;
  assign atHi = (wrAddr == KEY_ADDR_HI);
  assign atLo = (wrAddr == KEY_ADDR_LO);

  assign hits.first  = atHi && (wrData == KEY_FIRST);
  assign hits.second = atLo && (wrData == KEY_SECOND);
  assign hits.unlock = atHi && (wrData == KEY_UNLOCK);
  assign hits.extend = atHi && (wrData == KEY_EXTEND);
  assign hits.free   = atHi && (wrData == KEY_FREE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
      busyCnt <= '0;
    end else begin
      if (strobes.idleRestart)  idleCnt <= '0;
      else if (strobes.idleRun) idleCnt <= idleCnt + 1'b1;
      if (strobes.busyStart)    busyCnt <= '0;
      else if (strobes.busyRun) busyCnt <= busyCnt + 1'b1;
    end
  end

  assign idleExpired = (idleCnt == IDLE_LAST);
  assign busyDone    = (busyCnt == BUSY_LAST);

  // R8
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.idleRestart |=> idleCnt == '0);
  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busyStart |=> busyCnt == '0);
endmodule

// File: rtl/wp_cmd_ctrl.sv
module wp_cmd_ctrl
  import wp_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrValid,
  input  hit_t    hits,
  input  logic    idleExpired,
  input  logic    busyDone,
  output strobe_t strobes,
  output logic    commitOk,
  output logic    swallow,
  output logic    protectOn,
  output logic    busy
);
  step_e stepQ, stepNext;
  logic  winQ, busyQ, protectQ, pendLock, pendFree;
  logic  accept, match, closeWin, doneLock, doneFree;

  assign accept   = wrValid && !busyQ;
  assign closeWin = winQ && !accept && idleExpired;

  always_comb begin
    match    = 1'b0;
    stepNext = ST_IDLE;
    doneLock = 1'b0;
    doneFree = 1'b0;
    unique case (stepQ)
      ST_IDLE: begin match = hits.first;  stepNext = hits.first  ? ST_K1 : ST_IDLE; end
      ST_K1:   begin match = hits.second; stepNext = hits.second ? ST_K2 : ST_IDLE; end
      ST_K2: begin
        match    = hits.unlock || hits.extend;
        doneLock = hits.unlock;
        stepNext = hits.unlock ? ST_AUTH : (hits.extend ? ST_K3 : ST_IDLE);
      end
      ST_K3:   begin match = hits.first;  stepNext = hits.first  ? ST_K4 : ST_IDLE; end
      ST_K4:   begin match = hits.second; stepNext = hits.second ? ST_K5 : ST_IDLE; end
      ST_K5: begin
        match    = hits.free;
        doneFree = hits.free;
        stepNext = hits.free ? ST_AUTH : ST_IDLE;
      end
      default: begin match = 1'b0; stepNext = ST_AUTH; end
    endcase
  end

  assign swallow  = accept && match;
  assign commitOk = accept && !match && (!protectQ || stepQ == ST_AUTH);

  assign strobes.idleRestart = accept;
  assign strobes.idleRun     = winQ && !accept;
  assign strobes.busyStart   = closeWin;
  assign strobes.busyRun     = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ    <= ST_IDLE;
      winQ     <= 1'b0;
      busyQ    <= 1'b0;
      protectQ <= 1'b0;
      pendLock <= 1'b0;
      pendFree <= 1'b0;
    end else begin
      if (accept) begin
        winQ  <= 1'b1;
        stepQ <= stepNext;
        if (doneLock) pendLock <= 1'b1;
        if (doneFree) pendFree <= 1'b1;
      end else if (closeWin) begin
        winQ  <= 1'b0;
        busyQ <= 1'b1;
        stepQ <= ST_IDLE;
      end
      if (busyQ && busyDone) begin
        busyQ <= 1'b0;
        if (pendLock)      protectQ <= 1'b1;
        else if (pendFree) protectQ <= 1'b0;
        pendLock <= 1'b0;
        pendFree <= 1'b0;
      end
    end
  end

  assign protectOn = protectQ;
  assign busy      = busyQ;

  // R12
  protect_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(protectQ) |-> ($past(busyQ) && !busyQ));
  // R8
  busy_after_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(winQ));
  // R11
  quiet_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (!commitOk && !swallow));
  // R11
  step_hold_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busyQ) && busyQ) |-> $stable(stepQ));
endmodule

// File: rtl/wp_cmd_detect.sv
module wp_cmd_detect
  import wp_cmd_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 16,
  parameter int WRITE_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [14:0] wrAddr,
  input  logic [7:0]  wrData,
  output logic        commitOk,
  output logic        swallow,
  output logic        protectOn,
  output logic        busy
);
  strobe_t strobes;
  hit_t    hits;
  logic    idleExpired, busyDone;

  wp_cmd_dpath #(.LOAD_TIMEOUT(LOAD_TIMEOUT), .WRITE_CYCLES(WRITE_CYCLES)) dpath (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .hits(hits), .idleExpired(idleExpired), .busyDone(busyDone)
  );

  wp_cmd_ctrl ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .hits(hits),
    .idleExpired(idleExpired), .busyDone(busyDone), .strobes(strobes),
    .commitOk(commitOk), .swallow(swallow), .protectOn(protectOn), .busy(busy)
  );
endmodule

// File: tb/wp_cmd_detect_test.sv
module wp_cmd_detect_test;
  localparam int LT = 16;
  localparam int WC = 32;
  localparam int SETTLE = LT + WC + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic commitOk, swallow, protectOn, busy;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // reference model state
  int mStep = 0;       // 0..5 progress, 6 = authorised
  bit mWin = 0, mBusy = 0, mProt = 0, mPendLock = 0, mPendFree = 0;
  int mIdle = 0, mBusyCnt = 0;

  always #5 clk = ~clk;

  wp_cmd_detect #(.LOAD_TIMEOUT(LT), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .commitOk(commitOk), .swallow(swallow), .protectOn(protectOn), .busy(busy)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit keyHit(int s, logic [14:0] a, logic [7:0] d);
    bit hi, lo;
    hi = (a == 15'h5555);
    lo = (a == 15'h2AAA);
    case (s)
      0, 3:    return hi && d == 8'hAA;
      1, 4:    return lo && d == 8'h55;
      2:       return hi && (d == 8'hA0 || d == 8'h80);
      5:       return hi && d == 8'h20;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(bit v, logic [14:0] a, logic [7:0] d);
    bit acc, hit;
    @(negedge clk);
    wrValid = v; wrAddr = a; wrData = d;
    #1;
    acc = v && !mBusy;
    hit = acc && keyHit(mStep, a, d);
    chk(curReq, "swallow", swallow, hit);
    chk(curReq, "commitOk", commitOk, acc && !hit && (!mProt || mStep == 6));
    chk(curReq, "busy", busy, mBusy);
    chk(curReq, "protectOn", protectOn, mProt);
    // advance the model across the coming edge
    if (mBusy) begin
      if (mBusyCnt == WC - 1) begin
        mBusy = 0;
        if (mPendLock) mProt = 1;
        else if (mPendFree) mProt = 0;
        mPendLock = 0; mPendFree = 0;
      end else mBusyCnt++;
    end else if (acc) begin
      mWin = 1; mIdle = 0;
      if (hit) begin
        if (mStep == 2 && d == 8'hA0) begin mStep = 6; mPendLock = 1; end
        else if (mStep == 2) mStep = 3;
        else if (mStep == 5) begin mStep = 6; mPendFree = 1; end
        else mStep++;
      end else if (mStep != 6) mStep = 0;
    end else if (mWin) begin
      if (mIdle == LT - 1) begin mWin = 0; mBusy = 1; mBusyCnt = 0; mStep = 0; end
      else mIdle++;
    end
  endtask

  task automatic idleN(int n);
    for (int i = 0; i < n; i++) step(1'b0, 15'h0, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "protectOn", protectOn, 1'b0);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "commitOk", commitOk, 1'b0);
    chk("R1", "swallow", swallow, 1'b0);
    rstN = 1'b1;

    curReq = "R2";
    step(1, 15'h0123, 8'h5A);
    curReq = "R8";
    idleN(SETTLE);

    curReq = "R10";
    step(1, 15'h5555, 8'hAA);
    step(1, 15'h0100, 8'h11);
    idleN(SETTLE);

    curReq = "R3";
    step(1, 15'h5555, 8'hAA);
    step(1, 15'h2AAA, 8'h55);
    step(1, 15'h5555, 8'hA0);
    curReq = "R4";
    step(1, 15'h0040, 8'h77);
    idleN(SETTLE);
    chk("R4", "protectOn after write period", protectOn, 1'b1);

    curReq = "R5";
    step(1, 15'h0200, 8'h33);
    idleN(SETTLE);
    chk("R5", "protectOn kept", protectOn, 1'b1);

    curReq = "R6";
    step(1, 15'h5555, 8'hAA);
    step(1, 15'h2AAA, 8'h55);
    step(1, 15'h5555, 8'hA0);
    step(1, 15'h0300, 8'h44);
    step(1, 15'h0301, 8'h45);
    idleN(SETTLE);

    curReq = "R9";
    step(1, 15'h5555, 8'hAA);
    idleN(LT + 2);
    curReq = "R11";
    step(1, 15'h5555, 8'hAA);
    idleN(WC);
    curReq = "R9";
    step(1, 15'h2AAA, 8'h55);
    idleN(SETTLE);

    curReq = "R7";
    step(1, 15'h5555, 8'hAA);
    step(1, 15'h2AAA, 8'h55);
    step(1, 15'h5555, 8'h80);
    step(1, 15'h5555, 8'hAA);
    step(1, 15'h2AAA, 8'h55);
    step(1, 15'h5555, 8'h20);
    step(1, 15'h0400, 8'h99);
    curReq = "R12";
    idleN(LT + 4);
    chk("R12", "protectOn held during write period", protectOn, 1'b1);
    idleN(WC);
    chk("R7", "protectOn cleared", protectOn, 1'b0);

    curReq = "R2";
    step(1, 15'h5555, 8'h00);
    idleN(SETTLE);
    summary();
  end
endmodule